// File: doc/BRIEF.md
# Low-Switching Test Pattern Generator

This block supplies stimulus words for a built-in self-test of an 8-bit serial interface datapath. The aim is to keep the toggle count between one stimulus word and the next as low as possible. An index counter runs through every 8-bit value. Each index is converted to its reflected Gray code, and the result is XORed with a seed word held in a linear feedback shift register. While the seed is held constant, two successive words differ in exactly one bit, and one full sweep of 256 words still visits every 8-bit value exactly once. When a sweep ends, the seed register steps once, so the next sweep visits the same values in a different order.

Control is a three-state machine. IDLE is the state after reset. The transition IDLE to RUN is taken on an accepted start. RUN emits one word in each cycle that enable is high. The transition RUN to DONE is taken when the last word of the final sweep is emitted. DONE holds the finished flag. The transition DONE to RUN is taken on the next start. A reset returns the machine to IDLE from any state. The seed can be loaded only while the machine is outside RUN. The caller programs the number of sweeps as a count minus one, from 1 to 16.

Top module: `lbpg_top`

## Requirements
- R1: `rst` is synchronous and active high. In the cycle after a reset edge, `valid` = 0, `done` = 0, `pattern` = 8'h00, the seed is 8'h01 and the machine is in IDLE.
- R2: In RUN, each cycle with `enable` high emits one word. After that clock edge, `valid` = 1 and `pattern` = G(i) ^ S. Here i is the index since the last accepted start, counting up from 0, G(i) = i ^ (i >> 1), and S is the current seed.
- R3: Within one sweep, any two consecutive words with `valid` high differ in exactly one bit position, even when `enable` pauses fall between them.
- R4: Each sweep of 256 emitted words contains every 8-bit value exactly once.
- R5: A cycle in RUN with `enable` low emits nothing. After that edge `valid` = 0, `pattern` keeps its last value, and the index is held, so emission resumes at the next index.
- R6: On the 256th word of a sweep, the seed S becomes {S[6:0], S[7]^S[5]^S[4]^S[3]}, the Fibonacci form of x^8+x^6+x^5+x^4+1. The seed is never 8'h00.
- R7: `seed_load` high outside RUN sets the seed to `seed_in`, or to 8'h01 if `seed_in` is 8'h00. In RUN, `seed_load` is ignored.
- R8: `done` rises on the same edge as the last word of sweep number `sweeps_m1`+1. After that, `valid` stays 0 and `done` stays 1 until a start is accepted.
- R9: `start` is ignored in RUN. This holds for the index and for the sweep target. The value of `sweeps_m1` is sampled only on the edge where a start is accepted.
- R10: A start accepted in IDLE or DONE clears `done` and makes the next word use index 0. It keeps the current seed as it is and does not reload it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a run of sweeps (IDLE or DONE only) |
| seed_load | input | 1 | Load `seed_in` into the seed register outside RUN |
| seed_in | input | 8 | Seed value to load; zero is replaced by 8'h01 |
| enable | input | 1 | Emit one word this cycle when in RUN |
| sweeps_m1 | input | 4 | Number of sweeps minus one, sampled at start |
| pattern | output | 8 | Registered test word |
| valid | output | 1 | High for one cycle per emitted word |
| done | output | 1 | All programmed sweeps finished |

## Verification
The bench checks the wrap from index 255 back to 0. A design that steps the seed one word early or one word late breaks the single-bit change inside a sweep and repeats values within the sweep. Enable gaps at several periods expose a counter that slips or a `valid` flag that stays high during a pause. Seed loads and starts issued in RUN would corrupt the ongoing sweep if a design accepted them. A zero seed that is not replaced would freeze the register, so every later sweep would reuse the seed when it should have moved on. The run of 16 sweeps and the single-sweep runs together catch an off-by-one in the sweep count, which would make `done` rise one sweep early or one sweep late.

// File: rtl/lbpg_pkg.sv
package lbpg_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_DONE = 2'd2
    } lbpg_state_e;

    localparam int unsigned LBPG_WIDTH   = 8;
    localparam int unsigned LBPG_SWEEP_W = 4;

endpackage

// File: rtl/lbpg_lfsr.sv
module lbpg_lfsr #(
    parameter int unsigned    W    = 8,
    parameter logic [W-1:0]   TAPS = 8'hB8,
    parameter logic [W-1:0]   INIT = 8'h01
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] seed
);

    logic [W-1:0] q;
    logic [W-1:0] guarded;
    logic         fb;

    // Feedback is the parity of the tapped bits; shift toward the MSB.
    assign fb      = ^(q & TAPS);
    // An all-zero seed would lock the register, so substitute the reset value.
    assign guarded = (load_val == '0) ? INIT : load_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= INIT;
        end else if (load) begin
            q <= guarded;
        end else if (step) begin
            q <= {q[W-2:0], fb};
        end
    end

    assign seed = q;

endmodule

// File: rtl/lbpg_gray_ctr.sv
module lbpg_gray_ctr #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] gray,
    output logic         at_last
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (inc) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Reflected binary code: each bit is the XOR of a bit and its upper neighbour.
    genvar i;
    generate
        for (i = 0; i < W - 1; i++) begin : g_gray
            assign gray[i] = cnt_q[i] ^ cnt_q[i+1];
        end
    endgenerate
    assign gray[W-1] = cnt_q[W-1];

    assign at_last = (cnt_q == {W{1'b1}});

endmodule

// File: rtl/lbpg_ctrl.sv
module lbpg_ctrl
    import lbpg_pkg::*;
#(
    parameter int unsigned SW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          enable,
    input  logic          wrap,
    input  logic [SW-1:0] sweeps_m1,
    output logic          clear_idx,
    output logic          emit,
    output logic          seed_step,
    output logic          seed_open,
    output logic          run,
    output logic          done
);

    lbpg_state_e   state_q, state_d;
    logic [SW-1:0] tgt_q;
    logic [SW-1:0] sweep_q;
    logic          accept;
    logic          last_sweep;

    assign accept     = start && (state_q != S_RUN);
    assign last_sweep = (sweep_q == tgt_q);

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (start) state_d = S_RUN;
            S_RUN:   if (enable && wrap && last_sweep) state_d = S_DONE;
            S_DONE:  if (start) state_d = S_RUN;
            default: state_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Sweep bookkeeping: target sampled on accept, count advances on each wrap.
    always_ff @(posedge clk) begin
        if (rst) begin
            tgt_q   <= '0;
            sweep_q <= '0;
        end else if (accept) begin
            tgt_q   <= sweeps_m1;
            sweep_q <= '0;
        end else if (seed_step && !last_sweep) begin
            sweep_q <= sweep_q + 1'b1;
        end
    end

    // Outputs decoded from the current state.
    always_comb begin
        run       = (state_q == S_RUN);
        done      = (state_q == S_DONE);
        emit      = run && enable;
        seed_step = emit && wrap;
        seed_open = !run;
        clear_idx = accept;
    end

endmodule

// File: rtl/lbpg_top.sv
module lbpg_top
    import lbpg_pkg::*;
#(
    parameter int unsigned       WIDTH   = LBPG_WIDTH,
    parameter int unsigned       SWEEP_W = LBPG_SWEEP_W,
    parameter logic [WIDTH-1:0]  TAPS    = 8'hB8,
    parameter logic [WIDTH-1:0]  SEED0   = 8'h01
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               seed_load,
    input  logic [WIDTH-1:0]   seed_in,
    input  logic               enable,
    input  logic [SWEEP_W-1:0] sweeps_m1,
    output logic [WIDTH-1:0]   pattern,
    output logic               valid,
    output logic               done
);

    logic             clear_idx;
    logic             emit;
    logic             seed_step;
    logic             seed_open;
    logic             run_w;
    logic             wrap;
    logic [WIDTH-1:0] gray_w;
    logic [WIDTH-1:0] seed_w;
    logic [WIDTH-1:0] pat_q;
    logic             val_q;

    lbpg_ctrl #(.SW(SWEEP_W)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .enable    (enable),
        .wrap      (wrap),
        .sweeps_m1 (sweeps_m1),
        .clear_idx (clear_idx),
        .emit      (emit),
        .seed_step (seed_step),
        .seed_open (seed_open),
        .run       (run_w),
        .done      (done)
    );

    lbpg_gray_ctr #(.W(WIDTH)) u_idx (
        .clk     (clk),
        .rst     (rst),
        .clear   (clear_idx),
        .inc     (emit),
        .gray    (gray_w),
        .at_last (wrap)
    );

    lbpg_lfsr #(.W(WIDTH), .TAPS(TAPS), .INIT(SEED0)) u_seed (
        .clk      (clk),
        .rst      (rst),
        .load     (seed_load && seed_open),
        .step     (seed_step),
        .load_val (seed_in),
        .seed     (seed_w)
    );

    // Output stage: the word is registered, and held while nothing is emitted.
    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
            val_q <= 1'b0;
        end else begin
            val_q <= emit;
            if (emit) begin
                pat_q <= gray_w ^ seed_w;
            end
        end
    end

    assign pattern = pat_q;
    assign valid   = val_q;

endmodule

// File: rtl/lbpg_chk.sv
module lbpg_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst,
    input logic         start,
    input logic         enable,
    input logic         valid,
    input logic         done,
    input logic [W-1:0] pattern,
    input logic         run,
    input logic [W-1:0] seed
);

    logic         armed_q;
    logic [W-1:0] nvalid_q;
    logic [W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed_q  <= 1'b0;
            nvalid_q <= '0;
            last_q   <= '0;
        end else begin
            armed_q <= 1'b1;
            if (start && !run) begin
                nvalid_q <= '0;
            end else if (valid) begin
                nvalid_q <= nvalid_q + 1'b1;
                last_q   <= pattern;
            end
        end
    end

    // R1: the first cycle after reset is quiet.
    a_r1_reset_quiet: assert property (@(posedge clk) disable iff (rst)
        $rose(armed_q) |-> (!valid && !done && pattern == '0));

    // R3: consecutive words inside a sweep differ in one bit.
    a_r3_single_change: assert property (@(posedge clk) disable iff (rst)
        (valid && nvalid_q != '0) |-> ($countones(pattern ^ last_q) == 1));

    // R5: a paused cycle emits nothing.
    a_r5_pause_quiet: assert property (@(posedge clk) disable iff (rst)
        (run && !enable) |=> !valid);

    // R5: the word is held while valid is low.
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (armed_q && !valid) |-> $stable(pattern));

    // R6: the seed never reaches zero.
    a_r6_seed_nonzero: assert property (@(posedge clk) disable iff (rst)
        seed != '0);

    // R8: done holds until a start arrives.
    a_r8_done_hold: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R8: no words once the finished state has settled.
    a_r8_quiet_after: assert property (@(posedge clk) disable iff (rst)
        (armed_q && done && $past(done)) |-> !valid);

endmodule

bind lbpg_top lbpg_chk #(.W(WIDTH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .enable  (enable),
    .valid   (valid),
    .done    (done),
    .pattern (pattern),
    .run     (run_w),
    .seed    (seed_w)
);

// File: tb/tb_lbpg_top.sv
module tb_lbpg_top;

    localparam int N  = 256;
    localparam int NT = 5;
    // Fields: seed[19:12], sweeps_m1[11:8], pause period[7:0] (0 = never pause)
    localparam logic [19:0] TABLE [NT] = '{
        {8'h01, 4'd0,  8'd0},
        {8'hA5, 4'd2,  8'd3},
        {8'h00, 4'd1,  8'd0},
        {8'hFF, 4'd15, 8'd0},
        {8'h3C, 4'd0,  8'd2}
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       seed_load = 1'b0;
    logic       enable = 1'b0;
    logic [7:0] seed_in = 8'h00;
    logic [3:0] sweeps_m1 = 4'd0;
    logic [7:0] pattern;
    logic       valid;
    logic       done;

    always #4 clk = ~clk;

    lbpg_top dut (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .seed_load (seed_load),
        .seed_in   (seed_in),
        .enable    (enable),
        .sweeps_m1 (sweeps_m1),
        .pattern   (pattern),
        .valid     (valid),
        .done      (done)
    );

    int checks = 0;
    int fails  = 0;

    bit         m_run, m_done;
    int         m_idx, m_sweep, m_tgt;
    logic [7:0] m_seed, m_last, m_hold;
    bit         seen [N];
    int         seen_n, dup_n;

    function automatic logic [7:0] gray8(int b);
        logic [7:0] v = b[7:0];
        return v ^ (v >> 1);
    endfunction

    function automatic logic [7:0] lfsr_next(logic [7:0] s);
        return {s[6:0], s[7] ^ s[5] ^ s[4] ^ s[3]};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic clear_seen();
        for (int k = 0; k < N; k++) seen[k] = 1'b0;
        seen_n = 0;
        dup_n  = 0;
    endtask

    task automatic do_reset();
        rst = 1'b1; start = 1'b0; seed_load = 1'b0; enable = 1'b0;
        repeat (3) step();
        rst = 1'b0;
        step();
        m_run = 0; m_done = 0; m_idx = 0; m_sweep = 0; m_tgt = 0;
        m_seed = 8'h01; m_hold = 8'h00; m_last = 8'h00;
        clear_seen();
        check(valid == 1'b0, "R1", "valid after reset", valid, 0);
        check(done == 1'b0, "R1", "done after reset", done, 0);
        check(pattern == 8'h00, "R1", "pattern after reset", pattern, 0);
    endtask

    task automatic cycle(bit en);
        bit emit = m_run && en;
        enable = en; start = 1'b0; seed_load = 1'b0;
        step();
        if (emit) begin
            logic [7:0] e = gray8(m_idx) ^ m_seed;
            check(valid == 1'b1, "R2", "valid on emit", valid, 1);
            check(pattern == e, "R2", "pattern value", pattern, e);
            if (m_idx != 0)
                check($countones(pattern ^ m_last) == 1, "R3", "bit changes",
                      $countones(pattern ^ m_last), 1);
            if (seen[pattern]) dup_n++;
            else begin seen[pattern] = 1'b1; seen_n++; end
            m_last = pattern;
            m_hold = pattern;
            m_idx++;
            if (m_idx == N) begin
                check(seen_n == N && dup_n == 0, "R4", "distinct values in sweep", seen_n, N);
                clear_seen();
                m_idx  = 0;
                m_seed = lfsr_next(m_seed);
                if (m_sweep == m_tgt) begin m_run = 0; m_done = 1; end
                else m_sweep++;
            end
        end else begin
            check(valid == 1'b0, m_run ? "R5" : "R8", "valid low", valid, 0);
            check(pattern == m_hold, m_run ? "R5" : "R8", "pattern held", pattern, m_hold);
        end
        check(done == m_done, "R8", "done flag", done, m_done);
    endtask

    task automatic do_start(logic [3:0] m1);
        start = 1'b1; sweeps_m1 = m1; enable = 1'b0; seed_load = 1'b0;
        step();
        start = 1'b0;
        if (!m_run) begin
            m_run = 1; m_idx = 0; m_sweep = 0; m_tgt = m1; m_done = 0;
            clear_seen();
        end
        check(valid == 1'b0, "R9", "valid on start cycle", valid, 0);
        check(done == m_done, "R10", "done after start", done, m_done);
    endtask

    task automatic do_load(logic [7:0] v);
        seed_load = 1'b1; seed_in = v; enable = 1'b0; start = 1'b0;
        step();
        seed_load = 1'b0;
        if (!m_run) m_seed = (v == 8'h00) ? 8'h01 : v;
        check(valid == 1'b0, "R7", "valid on load cycle", valid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();

        // Table of runs: seed, sweep count, pause period.
        for (int t = 0; t < NT; t++) begin
            int c = 0;
            int pause = int'(TABLE[t][7:0]);
            do_load(TABLE[t][19:12]);
            do_start(TABLE[t][11:8]);
            while (m_run) begin
                cycle(!(pause != 0 && (c % pause) == pause - 1));
                c++;
            end
            cycle(1'b1);
        end

        // Directed: seed load and start ignored during a run.
        do_load(8'h5A);
        do_start(4'd0);
        repeat (10) cycle(1'b1);
        do_load(8'h77);
        cycle(1'b1);
        check(pattern == (gray8(10) ^ 8'h5A), "R7", "load ignored in run", pattern, gray8(10) ^ 8'h5A);
        do_start(4'd3);
        cycle(1'b1);
        check(pattern == (gray8(11) ^ 8'h5A), "R9", "start ignored in run", pattern, gray8(11) ^ 8'h5A);
        repeat (4) cycle(1'b0);
        cycle(1'b1);
        check(pattern == (gray8(12) ^ 8'h5A), "R5", "index resumes after pause", pattern, gray8(12) ^ 8'h5A);
        while (m_run) cycle(1'b1);
        check(done == 1'b1, "R9", "target kept from accepted start", done, 1);
        repeat (5) cycle(1'b1);
        check(done == 1'b1, "R8", "done still held", done, 1);

        // Directed: restart without reload keeps the advanced seed.
        do_start(4'd0);
        check(done == 1'b0, "R10", "done cleared by start", done, 0);
        cycle(1'b1);
        check(pattern == (8'h00 ^ lfsr_next(8'h5A)), "R6", "seed stepped after sweep",
              pattern, lfsr_next(8'h5A));
        check(pattern == (gray8(0) ^ m_seed), "R10", "index zero after restart", pattern, m_seed);
        repeat (20) cycle(1'b1);

        // Directed: reset in the middle of a run.
        do_reset();
        cycle(1'b1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule